// File: doc/BRIEF.md
# Serial Programming Instruction Receiver

This block is the target side of an in-system programming port. It runs on a fast system clock and oversamples three slow external lines: the serial clock, the serial data input and an active-high framing reset. The incoming bits are packed into fixed four-byte instructions. While it receives, the block shifts response bytes out on a serial data output. Each accepted instruction is handed to a memory command port as an opcode, two address bytes and a data byte.

After reset the port is disabled. It accepts only the programming-enable instruction. If any other instruction arrives first, the port treats this as lost framing and goes quiet. Only a pulse on the framing reset line brings it back. Once the port is enabled, every instruction is passed on. Three bytes into each instruction, a lookup pulse asks the memory side for read data. That data is returned during the fourth byte.

Top module: `isp_prog_port`

## Requirements
- R1: After system reset, `sdo_o`, `cmd_valid_o`, `cmd_peek_o` and `prog_en_o` are all 0.
- R2: Serial input is taken on each rising serial clock edge, most significant bit first. Bytes 0 to 3 of an instruction appear on `cmd_op_o`, `cmd_addr_hi_o`, `cmd_addr_lo_o` and `cmd_data_o`.
- R3: `sdo_o` changes only after a falling serial clock edge, a framing reset or a loss of framing. It never changes on a rising edge.
- R4: The output byte shifted during received byte 0 is 0x00. During byte 1 the block shifts out received byte 0, and during byte 2 it shifts out received byte 1. So a correct enable instruction returns 0x53 during its third byte.
- R5: While disabled, an instruction whose byte 0 is 0xAC and byte 1 is 0x53 sets `prog_en_o`, whatever bytes 2 and 3 hold. That instruction produces no `cmd_valid_o`.
- R6: While disabled, any other complete instruction loses framing. From then on, serial clock edges are ignored, `sdo_o` stays 0, no strobe occurs and `prog_en_o` stays 0, until a framing reset.
- R7: A high level on `trst_i` clears the bit and byte position, the enable and the lost-framing state. A new enable instruction is then framed from its first bit, even if the pulse came mid-instruction.
- R8: While enabled, each complete instruction raises `cmd_valid_o` for one system clock, together with all four received bytes.
- R9: While enabled, `cmd_peek_o` pulses for one clock after the 24th bit, with bytes 0 to 2 valid. The value on `rd_data_i` during that clock is shifted out during byte 3. While disabled, byte 3 instead echoes received byte 2.
- R10: `cmd_valid_o` and `cmd_peek_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| sck_i | input | 1 | Serial clock from the programmer (asynchronous) |
| sdi_i | input | 1 | Serial data into the target (asynchronous) |
| trst_i | input | 1 | Active-high framing reset line (asynchronous) |
| sdo_o | output | 1 | Serial data back to the programmer |
| prog_en_o | output | 1 | Programming session enabled |
| cmd_valid_o | output | 1 | One-cycle strobe for a complete instruction |
| cmd_peek_o | output | 1 | One-cycle read lookup request after byte 2 |
| cmd_op_o | output | 8 | Instruction byte 0 |
| cmd_addr_hi_o | output | 8 | Instruction byte 1 |
| cmd_addr_lo_o | output | 8 | Instruction byte 2 |
| cmd_data_o | output | 8 | Instruction byte 3 |
| rd_data_i | input | 8 | Read data, sampled while `cmd_peek_o` is high |

## Verification
The bench first sends a wrong instruction to a freshly reset port. A design that kept framing after it would still accept the later enable. A design that never echoed would return zeros where 0x12 and 0x53 are expected. A framing reset is then applied in the middle of an instruction. If the bit counter were not cleared, the following enable would be misaligned and never accepted. One instruction uses serial clock phases of exactly three system clocks. Under this tightest timing, a slow synchronizer or late response loading would shift wrong bits. Finally, read instructions check that the looked-up value lands in byte 3 and not in the echo slot.

// File: rtl/isp_pkg.sv
// Shared constants and types for the serial programming instruction receiver.
// Assumes fixed-length instructions made of whole bytes.
package isp_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int CNT_W       = $clog2(FRAME_BITS);
    localparam int BIT_IDX_W   = $clog2(BYTE_W);
    localparam int IDX_W       = CNT_W - BIT_IDX_W;

    localparam logic [BYTE_W-1:0] ENABLE_OP  = 8'hAC;
    localparam logic [BYTE_W-1:0] ENABLE_KEY = 8'h53;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [FRAME_BYTES-1:0][BYTE_W-1:0] frame_t;
endpackage

// File: rtl/isp_sync.sv
// Multi-stage synchronizer for a group of slow asynchronous lines.
// Also provides the previous synchronized sample, for edge detection.
// Assumes each line holds a level for longer than STAGES+1 system clocks.
module isp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], async_i};
    end

    // Keep the last synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= stg[STAGES-1];
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/isp_frame.sv
// Receive side: shifts serial bits in MSB first and stores each completed
// byte. It also raises the lookup and valid pulses and runs the enable and
// lost-framing state. Assumes rise_i and clr_i are synchronized one-cycle events.
module isp_frame
    import isp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             rise_i,
    input  logic             bit_i,
    input  byte_t            rd_data_i,
    output frame_t           bytes_o,
    output logic [CNT_W-1:0] bitcnt_o,
    output logic             valid_o,
    output logic             peek_o,
    output logic             en_o,
    output logic             lost_o,
    output byte_t            rdbuf_o
);
    byte_t            sh_q, sh_next;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx;
    logic             take, byte_end, is_enable;

    // Decode the current position and the next shift value.
    always_comb begin
        take      = rise_i && !lost_o;
        idx       = cnt_q[CNT_W-1:BIT_IDX_W];
        byte_end  = take && (cnt_q[BIT_IDX_W-1:0] == '1);
        sh_next   = {sh_q[BYTE_W-2:0], bit_i};
        is_enable = (bytes_o[0] == ENABLE_OP) && (bytes_o[1] == ENABLE_KEY);
    end

    // Store each completed byte in its own slot.
    for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)                               bytes_o[k] <= '0;
            else if (byte_end && idx == IDX_W'(k))    bytes_o[k] <= sh_next;
        end
    end

    // Bit counter, shift register, pulses and session state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            valid_o <= 1'b0;
            peek_o  <= 1'b0;
            en_o    <= 1'b0;
            lost_o  <= 1'b0;
            rdbuf_o <= '0;
        end else begin
            valid_o <= 1'b0;
            peek_o  <= 1'b0;
            if (peek_o) rdbuf_o <= rd_data_i;
            if (take) begin
                sh_q  <= sh_next;
                cnt_q <= cnt_q + 1'b1;
            end
            if (byte_end && idx == IDX_W'(FRAME_BYTES-2) && en_o)
                peek_o <= 1'b1;
            if (byte_end && idx == IDX_W'(FRAME_BYTES-1)) begin
                if (en_o)           valid_o <= 1'b1;
                else if (is_enable) en_o    <= 1'b1;
                else                lost_o  <= 1'b1;
            end
        end
    end

    assign bitcnt_o = cnt_q;
endmodule

// File: rtl/isp_tx.sv
// Transmit side: at each byte boundary it loads the response byte, and it
// shifts one bit per falling serial clock edge. Assumes fall_i is a
// synchronized one-cycle event and bitcnt_i is the position about to be sent.
module isp_tx
    import isp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             lost_i,
    input  logic             fall_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] bitcnt_i,
    input  frame_t           bytes_i,
    input  byte_t            rdbuf_i,
    output logic             sdo_o
);
    byte_t            tx_q, next_byte;
    logic [IDX_W-1:0] idx;
    logic             boundary;

    // Pick the byte to send in the slot that starts now.
    always_comb begin
        idx      = bitcnt_i[CNT_W-1:BIT_IDX_W];
        boundary = (bitcnt_i[BIT_IDX_W-1:0] == '0);
        if (idx == '0)                                 next_byte = '0;
        else if (idx == IDX_W'(FRAME_BYTES-1) && en_i) next_byte = rdbuf_i;
        else                                           next_byte = bytes_i[idx - 1'b1];
    end

    // Load or shift the output register on a falling serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || lost_i) tx_q <= '0;
        else if (fall_i) begin
            if (boundary) tx_q <= next_byte;
            else          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
    end

    assign sdo_o = tx_q[BYTE_W-1];
endmodule

// File: rtl/isp_prog_port.sv
// Top of the serial programming instruction receiver. It synchronizes the
// serial lines, detects serial clock edges, and joins the receive and
// transmit sides. Assumes each serial clock phase lasts at least three
// system clocks.
module isp_prog_port
    import isp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_i,
    input  logic        sdi_i,
    input  logic        trst_i,
    output logic        sdo_o,
    output logic        prog_en_o,
    output logic        cmd_valid_o,
    output logic        cmd_peek_o,
    output logic [7:0]  cmd_op_o,
    output logic [7:0]  cmd_addr_hi_o,
    output logic [7:0]  cmd_addr_lo_o,
    output logic [7:0]  cmd_data_o,
    input  logic [7:0]  rd_data_i
);
    logic [2:0]       s_now, s_prev;
    logic             rise_w, fall_w, clr_w, lost_w;
    frame_t           bytes_w;
    logic [CNT_W-1:0] bitcnt_w;
    byte_t            rdbuf_w;

    isp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({trst_i, sdi_i, sck_i}),
        .sync_o  (s_now),
        .prev_o  (s_prev)
    );

    // Turn synchronized samples into one-cycle edge and clear events.
    always_comb begin
        rise_w = s_now[0] && !s_prev[0];
        fall_w = !s_now[0] && s_prev[0];
        clr_w  = s_now[2];
    end

    isp_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_w),
        .rise_i    (rise_w),
        .bit_i     (s_now[1]),
        .rd_data_i (rd_data_i),
        .bytes_o   (bytes_w),
        .bitcnt_o  (bitcnt_w),
        .valid_o   (cmd_valid_o),
        .peek_o    (cmd_peek_o),
        .en_o      (prog_en_o),
        .lost_o    (lost_w),
        .rdbuf_o   (rdbuf_w)
    );

    isp_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr_w),
        .lost_i   (lost_w),
        .fall_i   (fall_w),
        .en_i     (prog_en_o),
        .bitcnt_i (bitcnt_w),
        .bytes_i  (bytes_w),
        .rdbuf_i  (rdbuf_w),
        .sdo_o    (sdo_o)
    );

    assign cmd_op_o      = bytes_w[0];
    assign cmd_addr_hi_o = bytes_w[1];
    assign cmd_addr_lo_o = bytes_w[2];
    assign cmd_data_o    = bytes_w[3];
endmodule

// File: rtl/isp_prog_port_chk.sv
// Protocol checker for isp_prog_port, attached to it with bind.
module isp_prog_port_chk (
    input logic clk,
    input logic rst_n,
    input logic rise_w,
    input logic fall_w,
    input logic clr_w,
    input logic lost_w,
    input logic sdo_o,
    input logic prog_en_o,
    input logic cmd_valid_o,
    input logic cmd_peek_o
);
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && cmd_peek_o));
    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    a_r8_valid_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> prog_en_o);
    a_r9_peek_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_peek_o |-> prog_en_o);
    a_r7_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> !prog_en_o);
    a_r6_lost_silent: assert property (@(posedge clk) disable iff (!rst_n)
        lost_w |=> (!sdo_o && !cmd_valid_o));
    a_r3_sdo_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> ($past(fall_w) || $past(clr_w) || $past(lost_w)));
    a_r5_enable_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en_o) |-> !cmd_valid_o);
    a_r3_not_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w && !clr_w && !lost_w) |=> $stable(sdo_o));
endmodule

bind isp_prog_port isp_prog_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_w      (rise_w),
    .fall_w      (fall_w),
    .clr_w       (clr_w),
    .lost_w      (lost_w),
    .sdo_o       (sdo_o),
    .prog_en_o   (prog_en_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_peek_o  (cmd_peek_o)
);

// File: tb/isp_prog_port_test.sv
`timescale 1ns/1ps
module isp_prog_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, trst = 1'b0;
    logic sdo, prog_en, vld, peek;
    logic [7:0] op, ahi, alo, dat, rdd;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] rd_fn(input logic [7:0] o, input logic [7:0] a, input logic [7:0] b);
        return (o ^ b) + {a[3:0], a[7:4]};
    endfunction

    assign rdd = rd_fn(op, ahi, alo);

    isp_prog_port uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .trst_i(trst),
        .sdo_o(sdo), .prog_en_o(prog_en), .cmd_valid_o(vld), .cmd_peek_o(peek),
        .cmd_op_o(op), .cmd_addr_hi_o(ahi), .cmd_addr_lo_o(alo), .cmd_data_o(dat),
        .rd_data_i(rdd)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: delayed input history plus instruction state.
    logic [2:0] hq[$];
    int         m_cnt;
    logic [7:0] m_sh, m_tx, m_rd;
    logic [7:0] m_b[4];
    bit         m_en, m_lost, m_valid, m_peek;

    function automatic logic [7:0] m_out(input int idx);
        if (idx == 0) return 8'h00;
        if (idx == 3 && m_en) return m_rd;
        return m_b[idx-1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hq = '{3'b0, 3'b0, 3'b0, 3'b0};
            m_cnt = 0; m_sh = 0; m_tx = 0; m_rd = 0;
            m_en = 0; m_lost = 0; m_valid = 0; m_peek = 0;
            for (int i = 0; i < 4; i++) m_b[i] = 8'h00;
        end else begin
            logic [2:0] cur, old;
            bit rs, fl;
            hq.push_front({trst, sdi, sck});
            void'(hq.pop_back());
            cur = hq[2];
            old = hq[3];
            rs = cur[0] && !old[0];
            fl = !cur[0] && old[0];
            if (cur[2]) begin
                m_cnt = 0; m_sh = 0; m_tx = 0; m_rd = 0;
                m_en = 0; m_lost = 0; m_valid = 0; m_peek = 0;
            end else begin
                if (m_lost) m_tx = 0;
                else if (fl) m_tx = (m_cnt % 8 == 0) ? m_out(m_cnt / 8) : (m_tx << 1);
                if (m_peek) m_rd = rd_fn(m_b[0], m_b[1], m_b[2]);
                m_valid = 0;
                m_peek = 0;
                if (rs && !m_lost) begin
                    m_sh = {m_sh[6:0], cur[1]};
                    if (m_cnt % 8 == 7) begin
                        m_b[m_cnt / 8] = m_sh;
                        if (m_cnt / 8 == 2 && m_en) m_peek = 1;
                        if (m_cnt / 8 == 3) begin
                            if (m_en) m_valid = 1;
                            else if (m_b[0] == 8'hAC && m_b[1] == 8'h53) m_en = 1;
                            else m_lost = 1;
                        end
                    end
                    m_cnt = (m_cnt + 1) % 32;
                end
            end
        end
    end

    // Compare the design against the model on every clock, away from the edge.
    logic [31:0] vq[$];
    always @(negedge clk) begin
        if (started) begin
            chk(sdo == m_tx[7], "R3 sdo", 32'(sdo), 32'(m_tx[7]));
            chk(vld == m_valid, "R10 valid", 32'(vld), 32'(m_valid));
            chk(peek == m_peek, "R10 peek", 32'(peek), 32'(m_peek));
            chk(prog_en == m_en, "R5 prog_en", 32'(prog_en), 32'(m_en));
            if (m_valid)
                chk({op, ahi, alo, dat} == {m_b[0], m_b[1], m_b[2], m_b[3]}, "R8 fields",
                    {op, ahi, alo, dat}, {m_b[0], m_b[1], m_b[2], m_b[3]});
            if (m_peek)
                chk({op, ahi, alo} == {m_b[0], m_b[1], m_b[2]}, "R9 peek fields",
                    32'({op, ahi, alo}), 32'({m_b[0], m_b[1], m_b[2]}));
            if (vld) vq.push_back({op, ahi, alo, dat});
        end
    end

    task automatic send_bit(input logic d, input int half, output logic q);
        sdi = d;
        repeat (half) @(negedge clk);
        q = sdo;
        sck = 1'b1;
        repeat (half) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic frame(input logic [31:0] w, input int half, output logic [31:0] rx);
        for (int i = 31; i >= 0; i--) begin
            logic q;
            send_bit(w[i], half, q);
            rx[i] = q;
        end
        repeat (half + 4) @(negedge clk);
    endtask

    task automatic pulse_trst();
        trst = 1'b1;
        repeat (4) @(negedge clk);
        trst = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_test();
    end

    initial begin
        logic [31:0] rx;
        logic [31:0] got;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        started = 1'b1;
        // R1 reset state
        chk(sdo == 0 && vld == 0 && peek == 0 && prog_en == 0, "R1",
            {sdo, vld, peek, prog_en}, 32'h0);

        // R6: wrong instruction while disabled loses framing; R4 echo still visible
        frame(32'h12345678, 4, rx);
        chk(rx == 32'h00123456, "R4 echo", rx, 32'h00123456);
        chk(vq.size() == 0, "R6 no strobe", vq.size(), 0);
        frame(32'hAC530000, 4, rx);
        chk(rx == 32'h0, "R6 sdo quiet", rx, 32'h0);
        chk(prog_en == 0, "R6 stays disabled", 32'(prog_en), 0);

        // R7 framing reset, then R5 enable with R4 echo of 0x53 and R9 disabled echo
        pulse_trst();
        frame(32'hAC531122, 4, rx);
        chk(rx[15:8] == 8'h53, "R4 key echo", 32'(rx[15:8]), 32'h53);
        chk(rx == 32'h00AC5311, "R9 disabled byte3", rx, 32'h00AC5311);
        chk(prog_en == 1, "R5 enabled", 32'(prog_en), 1);
        chk(vq.size() == 0, "R5 no strobe", vq.size(), 0);

        // R8/R9 read instructions while enabled
        frame(32'h20010200, 4, rx);
        chk(rx[7:0] == rd_fn(8'h20, 8'h01, 8'h02), "R9 read data", 32'(rx[7:0]), 32'(rd_fn(8'h20, 8'h01, 8'h02)));
        chk(rx[23:16] == 8'h20, "R4 op echo", 32'(rx[23:16]), 32'h20);
        got = (vq.size() > 0) ? vq.pop_front() : 32'hX;
        chk(got == 32'h20010200, "R2 fields", got, 32'h20010200);

        // R2 tightest serial clock phases of three system clocks
        frame(32'hC0AA55FF, 3, rx);
        got = (vq.size() > 0) ? vq.pop_front() : 32'hX;
        chk(got == 32'hC0AA55FF, "R2 fast clock", got, 32'hC0AA55FF);
        chk(rx[7:0] == rd_fn(8'hC0, 8'hAA, 8'h55), "R9 fast read", 32'(rx[7:0]), 32'(rd_fn(8'hC0, 8'hAA, 8'h55)));

        frame(32'h4C80003C, 5, rx);
        got = (vq.size() > 0) ? vq.pop_front() : 32'hX;
        chk(got == 32'h4C80003C, "R8 strobe", got, 32'h4C80003C);

        // R7 framing reset in the middle of an instruction
        for (int i = 0; i < 12; i++) begin
            logic q;
            send_bit(1'b1, 4, q);
        end
        repeat (4) @(negedge clk);
        pulse_trst();
        chk(prog_en == 0, "R7 session cleared", 32'(prog_en), 0);
        frame(32'hAC530000, 4, rx);
        chk(prog_en == 1, "R7 reframed enable", 32'(prog_en), 1);
        frame(32'hA0001077, 4, rx);
        got = (vq.size() > 0) ? vq.pop_front() : 32'hX;
        chk(got == 32'hA0001077, "R7 strobe after reframe", got, 32'hA0001077);
        chk(vq.size() == 0, "R10 one strobe per instruction", vq.size(), 0);

        repeat (10) @(negedge clk);
        finish_test();
    end
endmodule